// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block is the integer multiply and divide engine that sits beside a 32-bit pipeline. It owns a HI/LO result pair and accepts one command per idle cycle: an opcode plus two operands. Multiplies and divides take one result bit per clock through a shift-and-add or shift-and-subtract loop. Each long operation finishes after a fixed number of clocks. That number depends on the opcode and, for signed divide, on the operand signs. The surrounding pipeline can therefore predict exactly when HI/LO or the general-register result becomes valid.

Signed operations reduce the operands to magnitudes when the command is captured. The result sign is fixed in dedicated correction cycles after the loop, which is where the extra clocks of the sign-dependent divide come from. Multiply-accumulate adds the product to HI/LO, or subtracts it, in two half-width steps after the loop. A register-targeted multiply returns the low product word on its own port and leaves HI/LO alone. A command that arrives while an operation is running is refused with stall. The running operation keeps iterating no matter what is presented on the command port.

Top module: `iter_muldiv`

## Requirements
- R1: The opcode encoding on cmdOp is: 1 signed multiply, 2 unsigned multiply, 3 register-targeted multiply, 4 signed multiply-add, 5 unsigned multiply-add, 6 signed multiply-subtract, 7 unsigned multiply-subtract, 8 signed divide, 9 unsigned divide, 10 read HI, 11 read LO, 12 write HI, 13 write LO; 0, 14 and 15 do nothing. A command is taken on a rising edge where cmdValid is high and busy is low; opcodes 1 to 9 make busy high from the next cycle until the operation ends.
- R2: "Latency L" means done is high for exactly the one cycle that follows the L-th rising edge after the accepting edge. Signed and unsigned multiply leave the full 64-bit product in {HI,LO} with latency 32.
- R3: The register-targeted multiply presents the low 32 product bits on gprData, with gprValid and done high together, with latency 32. HI and LO keep their previous values. gprValid is never high without done.
- R4: Multiply-add sets {HI,LO} to {HI,LO} plus the product, and multiply-subtract sets it to {HI,LO} minus the product, modulo 2^64, signed or unsigned per opcode, with latency 34.
- R5: Unsigned divide puts the quotient in LO and the remainder in HI, with latency 33.
- R6: Signed divide truncates the quotient toward zero and gives the remainder the sign of the dividend (LO quotient, HI remainder). Latency is 33 when neither operand is negative, 34 when the divisor is negative, and 35 when only the dividend is negative.
- R7: Unsigned divide by zero gives LO = 32'hFFFFFFFF and HI = the dividend.
- R8: While busy, a presented command raises stall, is not executed and does not change HI/LO. The running operation finishes with its normal latency and result.
- R9: When idle, a read-HI or read-LO command shows the register on readData in the same cycle, without stall. While busy, such a request gets stall.
- R10: Write-HI and write-LO load opA into the register at the accepting edge and do not raise busy.
- R11: After reset, busy, stall, done and gprValid are low and HI and LO read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Opcode, encoding in R1 |
| opA | input | 32 | First operand: multiplicand, dividend, or value for a HI/LO write |
| opB | input | 32 | Second operand: multiplier or divisor |
| stall | output | 1 | Command refused because an operation is running |
| busy | output | 1 | A long operation is in progress |
| done | output | 1 | One-cycle pulse when a long operation has completed |
| gprValid | output | 1 | Register-targeted multiply result is valid on gprData |
| gprData | output | 32 | Low product word of the register-targeted multiply |
| readData | output | 32 | HI or LO for a read command, combinational |

## Verification
The embedded properties check on every cycle the following: a long command raises busy, and done arrives exactly at the latency expected for the captured opcode and signs. They also check that done is never seen with busy, that gprValid always coincides with done, that HI/LO cannot move while busy except on the completing edge, and that register writes land without busy. The arithmetic needs the bench's scenarios. Those cover the signed product of the most negative values, accumulation wrapping across 64 bits, every sign combination of divide, the quotient overflow case, and division by zero. Only these scenarios can show that a refused command leaves the result intact and that HI/LO survive the register-targeted multiply.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam logic [3:0] OP_MULT  = 4'd1;
  localparam logic [3:0] OP_MULTU = 4'd2;
  localparam logic [3:0] OP_MULG  = 4'd3;
  localparam logic [3:0] OP_MADD  = 4'd4;
  localparam logic [3:0] OP_MADDU = 4'd5;
  localparam logic [3:0] OP_MSUB  = 4'd6;
  localparam logic [3:0] OP_MSUBU = 4'd7;
  localparam logic [3:0] OP_DIV   = 4'd8;
  localparam logic [3:0] OP_DIVU  = 4'd9;
  localparam logic [3:0] OP_MFHI  = 4'd10;
  localparam logic [3:0] OP_MFLO  = 4'd11;
  localparam logic [3:0] OP_MTHI  = 4'd12;
  localparam logic [3:0] OP_MTLO  = 4'd13;

  typedef enum logic [3:0] {
    S_IDLE, S_ITER, S_MFIN, S_PNEG, S_ACCL, S_ACCH, S_DFIX1, S_DFIX2, S_DWB
  } mdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMul;
    logic loadDiv;
    logic signedOp;
    logic stepMul;
    logic stepDiv;
    logic prodNeg;
    logic negProd;
    logic finHiLo;
    logic finGpr;
    logic accLo;
    logic accHi;
    logic accSub;
    logic negQ;
    logic negR;
    logic wbDiv;
    logic wrHi;
    logic wrLo;
  } mdStrobe_t;

  function automatic logic isLongOp(input logic [3:0] op);
    return (op >= OP_MULT) && (op <= OP_DIVU);
  endfunction

  function automatic logic isMulOp(input logic [3:0] op);
    return (op >= OP_MULT) && (op <= OP_MSUBU);
  endfunction

  function automatic logic isSignedOp(input logic [3:0] op);
    return (op == OP_MULT) || (op == OP_MULG) || (op == OP_MADD) ||
           (op == OP_MSUB) || (op == OP_DIV);
  endfunction

endpackage

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] mulU,
  input  logic [W-1:0] mulL,
  input  logic [W-1:0] mulM,
  input  logic [W-1:0] remU,
  input  logic [W-1:0] quoL,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] mulUNx,
  output logic [W-1:0] mulLNx,
  output logic [W-1:0] divUNx,
  output logic [W-1:0] divLNx
);

  logic [W:0] mulSum;
  logic [W:0] divShift;
  logic [W:0] divDiff;
  logic       divFits;

  // one multiplier bit: conditional add, then shift right across the pair
  always_comb begin
    mulSum = {1'b0, mulU} + (mulL[0] ? {1'b0, mulM} : {(W+1){1'b0}});
    mulUNx = mulSum[W:1];
    mulLNx = {mulSum[0], mulL[W-1:1]};
  end

  // one quotient bit: restoring subtract on the shifted partial remainder
  always_comb begin
    divShift = {remU, quoL[W-1]};
    divDiff  = divShift - {1'b0, dvs};
    divFits  = ~divDiff[W];
    divUNx   = divFits ? divDiff[W-1:0] : divShift[W-1:0];
    divLNx   = {quoL[W-2:0], divFits};
  end

endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [3:0] cmdOp,
  input  logic       opASign,
  input  logic       opBSign,
  output logic       busy,
  output logic       stall,
  output logic       done,
  output logic       gprValid,
  output mdStrobe_t  strb
);

  localparam int CW = $clog2(W);
  localparam int LW = $clog2(W + 4) + 1;
  localparam logic [CW-1:0] MUL_ITERS = CW'(W - 2);
  localparam logic [CW-1:0] DIV_ITERS = CW'(W - 1);

  mdState_e     state, stateNx;
  logic [CW-1:0] cnt;
  logic [3:0]    opR;
  logic          aNegR, bNegR;
  logic          accept;
  logic          cmdSigned;

  assign busy      = (state != S_IDLE);
  assign stall     = cmdValid && busy;
  assign accept    = cmdValid && !busy;
  assign cmdSigned = isSignedOp(cmdOp);

  always_comb begin
    strb         = '0;
    stateNx      = state;
    strb.prodNeg = aNegR ^ bNegR;
    strb.accSub  = (opR == OP_MSUB) || (opR == OP_MSUBU);
    unique case (state)
      S_IDLE: begin
        strb.signedOp = cmdSigned;
        if (accept) begin
          if (isMulOp(cmdOp)) begin
            strb.loadMul = 1'b1;
            stateNx      = S_ITER;
          end else if (cmdOp == OP_DIV || cmdOp == OP_DIVU) begin
            strb.loadDiv = 1'b1;
            stateNx      = S_ITER;
          end
          strb.wrHi = (cmdOp == OP_MTHI);
          strb.wrLo = (cmdOp == OP_MTLO);
        end
      end
      S_ITER: begin
        if (opR == OP_DIV || opR == OP_DIVU) strb.stepDiv = 1'b1;
        else                                 strb.stepMul = 1'b1;
        if (cnt == '0) begin
          if (opR == OP_DIV || opR == OP_DIVU)
            stateNx = (aNegR || bNegR) ? S_DFIX1 : S_DWB;
          else if (opR >= OP_MADD)
            stateNx = S_PNEG;
          else
            stateNx = S_MFIN;
        end
      end
      S_MFIN: begin
        if (opR == OP_MULG) strb.finGpr  = 1'b1;
        else                strb.finHiLo = 1'b1;
        stateNx = S_IDLE;
      end
      S_PNEG: begin
        strb.negProd = 1'b1;
        stateNx      = S_ACCL;
      end
      S_ACCL: begin
        strb.accLo = 1'b1;
        stateNx    = S_ACCH;
      end
      S_ACCH: begin
        strb.accHi = 1'b1;
        stateNx    = S_IDLE;
      end
      S_DFIX1: begin
        strb.negQ = aNegR ^ bNegR;
        strb.negR = aNegR && bNegR;
        stateNx   = (aNegR && !bNegR) ? S_DFIX2 : S_DWB;
      end
      S_DFIX2: begin
        strb.negR = 1'b1;
        stateNx   = S_DWB;
      end
      S_DWB: begin
        strb.wbDiv = 1'b1;
        stateNx    = S_IDLE;
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      opR      <= '0;
      aNegR    <= 1'b0;
      bNegR    <= 1'b0;
      done     <= 1'b0;
      gprValid <= 1'b0;
    end else begin
      state    <= stateNx;
      done     <= busy && (stateNx == S_IDLE);
      gprValid <= (state == S_MFIN) && (opR == OP_MULG);
      if (accept && isLongOp(cmdOp)) begin
        opR   <= cmdOp;
        aNegR <= cmdSigned && opASign;
        bNegR <= cmdSigned && opBSign;
        cnt   <= isMulOp(cmdOp) ? MUL_ITERS : DIV_ITERS;
      end else if (state == S_ITER && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // ---------------- checking ----------------
  logic [LW-1:0] chkCnt;
  logic [LW-1:0] expLat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          chkCnt <= '0;
    else if (accept && isLongOp(cmdOp))  chkCnt <= '0;
    else if (busy)                       chkCnt <= chkCnt + 1'b1;
  end

  always_comb begin
    if (opR == OP_DIVU)                          expLat = LW'(W + 1);
    else if (opR == OP_DIV)                      expLat = bNegR ? LW'(W + 2) :
                                                          aNegR ? LW'(W + 3) : LW'(W + 1);
    else if (opR >= OP_MADD && opR <= OP_MSUBU)  expLat = LW'(W + 2);
    else                                         expLat = LW'(W);
  end

  a_r2_latency_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chkCnt == expLat));

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_gpr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    gprValid |-> done);

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mdStrobe_t    strb,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic [W-1:0] gprData
);

  localparam int PW = 2 * W;

  logic [W-1:0]  uR, lR, dR, hiR, loR, gprR;
  logic          carryR;
  logic [W-1:0]  magA, magB;
  logic [W-1:0]  mulU, mulL, mulM;
  logic [W-1:0]  mulUNx, mulLNx, divUNx, divLNx;
  logic [PW-1:0] prod, prodFixed;
  logic [W:0]    addLo;
  logic [W-1:0]  addHi;
  logic [W-1:0]  lOpnd, uOpnd;

  // magnitudes for signed commands
  always_comb begin
    magA = (strb.signedOp && opA[W-1]) ? (~opA + 1'b1) : opA;
    magB = (strb.signedOp && opB[W-1]) ? (~opB + 1'b1) : opB;
  end

  // the capture cycle also performs the first multiplier step
  always_comb begin
    mulU = strb.loadMul ? '0   : uR;
    mulL = strb.loadMul ? magB : lR;
    mulM = strb.loadMul ? magA : dR;
  end

  muldiv_step #(.W(W)) step_i (
    .mulU   (mulU),
    .mulL   (mulL),
    .mulM   (mulM),
    .remU   (uR),
    .quoL   (lR),
    .dvs    (dR),
    .mulUNx (mulUNx),
    .mulLNx (mulLNx),
    .divUNx (divUNx),
    .divLNx (divLNx)
  );

  always_comb begin
    prod      = {uR, lR};
    prodFixed = strb.prodNeg ? (~prod + 1'b1) : prod;
    lOpnd     = strb.accSub ? ~lR : lR;
    uOpnd     = strb.accSub ? ~uR : uR;
    addLo     = {1'b0, loR} + {1'b0, lOpnd} + {{W{1'b0}}, strb.accSub};
    addHi     = hiR + uOpnd + {{(W-1){1'b0}}, carryR};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uR     <= '0;
      lR     <= '0;
      dR     <= '0;
      carryR <= 1'b0;
    end else begin
      if (strb.loadMul) begin
        uR <= mulUNx;
        lR <= mulLNx;
        dR <= magA;
      end else if (strb.loadDiv) begin
        uR <= '0;
        lR <= magA;
        dR <= magB;
      end else if (strb.stepMul) begin
        uR <= mulUNx;
        lR <= mulLNx;
      end else if (strb.stepDiv) begin
        uR <= divUNx;
        lR <= divLNx;
      end else if (strb.negProd) begin
        {uR, lR} <= prodFixed;
      end else if (strb.accLo) begin
        lR     <= addLo[W-1:0];
        carryR <= addLo[W];
      end else begin
        if (strb.negQ) lR <= ~lR + 1'b1;
        if (strb.negR) uR <= ~uR + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiR  <= '0;
      loR  <= '0;
      gprR <= '0;
    end else begin
      if (strb.wrHi) hiR <= opA;
      if (strb.wrLo) loR <= opA;
      if (strb.finHiLo) {hiR, loR} <= prodFixed;
      if (strb.finGpr) gprR <= prodFixed[W-1:0];
      if (strb.accHi) begin
        hiR <= addHi;
        loR <= lR;
      end
      if (strb.wbDiv) begin
        hiR <= uR;
        loR <= lR;
      end
    end
  end

  assign hi      = hiR;
  assign lo      = loR;
  assign gprData = gprR;

  // a remainder never reaches the divisor once the loop has started
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepDiv && dR != '0) |-> (uR < dR));

endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmdValid,
  input  logic [3:0]   cmdOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         stall,
  output logic         busy,
  output logic         done,
  output logic         gprValid,
  output logic [W-1:0] gprData,
  output logic [W-1:0] readData
);

  mdStrobe_t    strb;
  logic [W-1:0] hiW, loW;

  muldiv_ctrl #(.W(W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .opASign  (opA[W-1]),
    .opBSign  (opB[W-1]),
    .busy     (busy),
    .stall    (stall),
    .done     (done),
    .gprValid (gprValid),
    .strb     (strb)
  );

  muldiv_dp #(.W(W)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .hi      (hiW),
    .lo      (loW),
    .gprData (gprData)
  );

  assign readData = (cmdOp == OP_MFHI) ? hiW : loW;

  a_r1_long_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy && isLongOp(cmdOp)) |=> busy);

  a_r8_hilo_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || ($stable(hiW) && $stable(loW))));

  a_r10_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy && cmdOp == OP_MTHI) |=> (!busy && hiW == $past(opA)));

endmodule

// File: tb/iter_muldiv_tb_top.sv
module iter_muldiv_tb_top;

  localparam logic [3:0] C_MULT = 4'd1, C_MULTU = 4'd2, C_MULG = 4'd3,
                         C_MADD = 4'd4, C_MADDU = 4'd5, C_MSUB = 4'd6,
                         C_MSUBU = 4'd7, C_DIV = 4'd8, C_DIVU = 4'd9,
                         C_MFHI = 4'd10, C_MFLO = 4'd11, C_MTHI = 4'd12,
                         C_MTLO = 4'd13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = 4'd0;
  logic [31:0] opA = '0, opB = '0;
  logic        stall, busy, done, gprValid;
  logic [31:0] gprData, readData;

  always #4 clk = ~clk;

  iter_muldiv dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .opA(opA), .opB(opB), .stall(stall), .busy(busy), .done(done),
    .gprValid(gprValid), .gprData(gprData), .readData(readData)
  );

  typedef struct {
    int unsigned accCyc;
    int unsigned lat;
    bit          isGpr;
    logic [31:0] gpr;
    string       req;
  } expItem_t;

  expItem_t    sbQ[$];
  int          pending = 0;
  int          nChecks = 0;
  int          nErrors = 0;
  int unsigned cyc = 0;
  logic [31:0] mHi = '0, mLo = '0;
  bit          finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected completion and compare as the design produces it
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbQ.size() == 0) begin
        chk(1'b0, "R2 unexpected done", 64'd1, 64'd0);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        chk(cyc - it.accCyc == it.lat, {it.req, " latency"},
            64'(cyc - it.accCyc), 64'(it.lat));
        chk(gprValid == it.isGpr, {it.req, " gprValid"}, 64'(gprValid), 64'(it.isGpr));
        if (it.isGpr) chk(gprData == it.gpr, {it.req, " gprData"}, 64'(gprData), 64'(it.gpr));
        pending--;
      end
    end
  end

  task automatic readHiLo(input logic [31:0] eHi, input logic [31:0] eLo, input string req);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = C_MFHI;
    #1 chk(readData == eHi && !stall, {req, " HI"}, 64'(readData), 64'(eHi));
    cmdOp = C_MFLO;
    #1 chk(readData == eLo && !stall, {req, " LO"}, 64'(readData), 64'(eLo));
    cmdValid = 1'b0; cmdOp = 4'd0;
  endtask

  task automatic writeReg(input logic [3:0] op, input logic [31:0] v);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; opA = v;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 4'd0;
    chk(!busy, "R10 no busy after write", 64'(busy), 64'd0);
    if (op == C_MTHI) mHi = v; else mLo = v;
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int unsigned lat, input bit isGpr, input logic [31:0] gpr,
                       input string req);
    expItem_t it;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; opA = a; opB = b;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 4'd0;
    chk(busy, {req, " busy after accept (R1)"}, 64'(busy), 64'd1);
    it.accCyc = cyc; it.lat = lat; it.isGpr = isGpr; it.gpr = gpr; it.req = req;
    sbQ.push_back(it);
    pending++;
  endtask

  task automatic runMul(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string req);
    logic [63:0] p;
    if (op == C_MULT || op == C_MULG || op == C_MADD || op == C_MSUB)
      p = 64'(longint'($signed(a)) * longint'($signed(b)));
    else
      p = {32'd0, a} * {32'd0, b};
    if (op == C_MULG) begin
      issue(op, a, b, 32, 1'b1, p[31:0], req);
    end else if (op == C_MULT || op == C_MULTU) begin
      issue(op, a, b, 32, 1'b0, '0, req);
      {mHi, mLo} = p;
    end else begin
      issue(op, a, b, 34, 1'b0, '0, req);
      if (op == C_MADD || op == C_MADDU) {mHi, mLo} = {mHi, mLo} + p;
      else                               {mHi, mLo} = {mHi, mLo} - p;
    end
    wait (pending == 0);
    readHiLo(mHi, mLo, req);
  endtask

  task automatic runDiv(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string req);
    int unsigned lat;
    longint qa, qb;
    if (op == C_DIVU) begin
      lat = 33;
      if (b == 0) begin mLo = 32'hFFFF_FFFF; mHi = a; end
      else begin mLo = a / b; mHi = a % b; end
    end else begin
      qa = longint'($signed(a)); qb = longint'($signed(b));
      lat = b[31] ? 34 : (a[31] ? 35 : 33);
      mLo = 32'(qa / qb); mHi = 32'(qa % qb);
    end
    issue(op, a, b, lat, 1'b0, '0, req);
    wait (pending == 0);
    readHiLo(mHi, mLo, req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !stall && !done && !gprValid, "R11 reset outputs",
        64'({busy, stall, done, gprValid}), 64'd0);
    readHiLo(32'd0, 32'd0, "R11 reset HI/LO");

    // R10 / R9 register moves
    writeReg(C_MTHI, 32'h1234_5678);
    writeReg(C_MTLO, 32'h9ABC_DEF0);
    readHiLo(32'h1234_5678, 32'h9ABC_DEF0, "R9 R10 move");

    // R2 multiplies
    runMul(C_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 multu max");
    runMul(C_MULT, 32'hFFFF_FFFD, 32'd7, "R2 mult neg");
    runMul(C_MULT, 32'h8000_0000, 32'h8000_0000, "R2 mult minneg");
    runMul(C_MULT, 32'h0001_2345, 32'hFFFE_0001, "R2 mult mixed");

    // R3 register-targeted multiply keeps HI/LO
    writeReg(C_MTHI, 32'hCAFE_0001);
    writeReg(C_MTLO, 32'hBEEF_0002);
    runMul(C_MULG, 32'hFFFF_FFFB, 32'd123456, "R3 mul gpr");

    // R4 accumulate
    writeReg(C_MTHI, 32'h0000_0001);
    writeReg(C_MTLO, 32'hFFFF_FFF0);
    runMul(C_MADDU, 32'h0000_0100, 32'h0000_0020, "R4 maddu carry");
    runMul(C_MADD, 32'hFFFF_FF00, 32'h0000_0003, "R4 madd neg");
    runMul(C_MSUB, 32'h7FFF_FFFF, 32'h0000_0002, "R4 msub");
    writeReg(C_MTHI, 32'd0);
    writeReg(C_MTLO, 32'd5);
    runMul(C_MSUBU, 32'd3, 32'd4, "R4 msubu wrap");

    // R5 / R7 unsigned divide
    runDiv(C_DIVU, 32'd100, 32'd7, "R5 divu");
    runDiv(C_DIVU, 32'hFFFF_FFFF, 32'h0001_0000, "R5 divu large");
    runDiv(C_DIVU, 32'h0BAD_F00D, 32'd0, "R7 divu by zero");

    // R6 signed divide, all sign patterns
    runDiv(C_DIV, 32'd7, 32'd2, "R6 div pos/pos");
    runDiv(C_DIV, 32'd7, 32'hFFFF_FFFE, "R6 div pos/neg");
    runDiv(C_DIV, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6 div neg/neg");
    runDiv(C_DIV, 32'hFFFF_FFF9, 32'd2, "R6 div neg/pos");
    runDiv(C_DIV, 32'h8000_0000, 32'hFFFF_FFFF, "R6 div overflow");

    // R8 / R9 commands during an operation are refused
    begin
      longint qa;
      qa = -1000;
      mLo = 32'(qa / 33); mHi = 32'(qa % 33);
      issue(C_DIV, 32'(qa), 32'd33, 35, 1'b0, '0, "R8 busy div");
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        cmdValid = 1'b1; cmdOp = C_MTHI; opA = 32'hDEAD_BEEF;
        #1 chk(stall && busy, "R8 stall on write", 64'({stall, busy}), 64'd3);
        cmdOp = C_MFLO;
        #1 chk(stall, "R9 stall on read", 64'(stall), 64'd1);
        cmdOp = C_MTHI;
      end
      @(negedge clk);
      cmdValid = 1'b0; cmdOp = 4'd0;
      wait (pending == 0);
      readHiLo(mHi, mLo, "R8 result intact");
    end

    repeat (2) @(negedge clk);
    chk(sbQ.size() == 0, "R2 scoreboard drained", 64'(sbQ.size()), 64'd0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule